// File: doc/BRIEF.md
# Memory Write-Path Error Injector

This block sits in line with the write request stream of one memory channel and corrupts selected writes on purpose, so that the error detection and correction logic further down can be tested. Software loads an address pattern, a per-bit don't-care mask and a check-bit flip mask, then writes a command word that arms one or both kinds of corruption. Check-bit corruption flips the chosen ECC bits of a write. Address-parity corruption inverts the parity bit sent with a write. Both kinds use the same address match.

Requests enter with address, data, check bits and a beat index within the cache line. They leave one cycle later with an even address parity bit added. Only writes whose address matches can be corrupted, and only while the command is armed. Reads always pass through unchanged. In one-shot mode the first write that takes an injection uses up the arming. In repeat mode every matching write is corrupted until the command changes. A status output shows that an injection has happened since the last command write.

Top module: `wpath_err_inject`

## Requirements
- R1: Read requests (req_write = 0) leave with out_ecc equal to req_ecc and out_apar equal to the XOR of all address bits. No read ever counts as an injection.
- R2: A write matches when ((req_addr XOR pattern) AND NOT dont_care) is zero. Pattern is configuration register 0, dont_care is register 1 and the flip mask is register 2, each loaded through cfg_sel.
- R3: With command bit 2 (repeat) clear, only the first write that takes an injection is corrupted. Later matching writes pass unchanged until the next command write.
- R4: With command bit 2 set, every matching write is corrupted for as long as the command stays unchanged.
- R5: Writing an all-zero command word (register 3) turns off all injection.
- R6: Command bit 0 enables check-bit corruption and command bit 1 enables address-parity corruption. Either may be set alone. When both are set, both corruptions land on the same matching write.
- R7: Check-bit corruption outputs req_ecc XOR flip mask. Parity corruption outputs the inverse of the XOR of all address bits.
- R8: With command bit 3 (half line) set, check bits are flipped only on beats below BEATS/2. A matching upper-half write with parity injection off takes no injection and does not use up a one-shot.
- R9: Any command write clears the injected status flag. A request in the same cycle as a configuration write is still handled with the old settings.
- R10: Every request appears at the outputs exactly one cycle after it is presented, with address, data and the write flag unchanged.
- R11: While reset is asserted, out_valid and inj_status are 0 and all configuration registers are zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 pattern, 1 don't-care, 2 flip mask, 3 command |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_beat | input | BEAT_W | Beat index within the line |
| req_data | input | DATA_W | Request data |
| req_ecc | input | ECC_W | Check bits from the generator |
| out_valid | output | 1 | Request present at the output |
| out_write | output | 1 | Write flag, passed through |
| out_addr | output | ADDR_W | Address, passed through |
| out_data | output | DATA_W | Data, passed through |
| out_ecc | output | ECC_W | Check bits, possibly corrupted |
| out_apar | output | 1 | Even address parity, possibly inverted |
| inj_status | output | 1 | An injection has happened since the last command write |

## Verification
A request driven before clock edge N appears on the out_* ports after edge N. inj_status changes at that same edge. A configuration write takes effect for requests presented in the following cycle. The bench drives each input half a cycle before an edge and samples on the next falling edge, so every result is read exactly one edge after its stimulus. A command write and its first request always sit in separate cycles, except in the directed test that checks same-cycle ordering.

// File: rtl/wpi_pkg.sv
package wpi_pkg;
  typedef struct packed {
    logic half_line;
    logic repeat_en;
    logic par_en;
    logic ecc_en;
  } inj_cmd_t;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    SEL_PATTERN  = 2'd0,
    SEL_DONTCARE = 2'd1,
    SEL_FLIPMASK = 2'd2,
    SEL_COMMAND  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/wpi_cfg_regs.sv
module wpi_cfg_regs
  import wpi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ECC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] pattern_q,
  output logic [ADDR_W-1:0] dontcare_q,
  output logic [ECC_W-1:0]  flipmask_q,
  output inj_cmd_t          cmd_q,
  output logic              cmd_wr
);
  logic              pat_en, dc_en, fm_en;
  inj_cmd_t          cmd_d;

  always_comb begin
    pat_en = cfg_we && (cfg_sel == SEL_PATTERN);
    dc_en  = cfg_we && (cfg_sel == SEL_DONTCARE);
    fm_en  = cfg_we && (cfg_sel == SEL_FLIPMASK);
    cmd_wr = cfg_we && (cfg_sel == SEL_COMMAND);
    cmd_d  = inj_cmd_t'(cfg_wdata[CMD_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q  <= '0;
      dontcare_q <= '0;
      flipmask_q <= '0;
      cmd_q      <= '0;
    end else begin
      if (pat_en) pattern_q  <= cfg_wdata;
      if (dc_en)  dontcare_q <= cfg_wdata;
      if (fm_en)  flipmask_q <= cfg_wdata[ECC_W-1:0];
      if (cmd_wr) cmd_q      <= cmd_d;
    end
  end

  // R5: an all-zero command leaves every injection enable clear
  p_zero_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cfg_wdata[CMD_W-1:0] == '0) |=> (cmd_q == '0));
endmodule

// File: rtl/wpi_addr_match.sv
module wpi_addr_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pattern,
  input  logic [ADDR_W-1:0] dontcare,
  output logic              match
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign bit_ok[g] = dontcare[g] | ~(addr[g] ^ pattern[g]);
  end

  assign match = &bit_ok;
endmodule

// File: rtl/wpi_arm_ctrl.sv
module wpi_arm_ctrl
  import wpi_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  inj_cmd_t          cmd_q,
  input  logic              cmd_wr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BEAT_W-1:0] req_beat,
  input  logic              match,
  output logic              do_ecc,
  output logic              do_par,
  output logic              fired_q
);
  localparam logic [BEAT_W-1:0] HALF_BEAT = BEAT_W'(BEATS / 2);

  logic lower_half, armed, ecc_elig, hit, fired_d;

  always_comb begin
    lower_half = (req_beat < HALF_BEAT);
    armed      = cmd_q.repeat_en | ~fired_q;
    ecc_elig   = cmd_q.ecc_en & (~cmd_q.half_line | lower_half);
    hit        = req_valid & req_write & match & armed & (ecc_elig | cmd_q.par_en);
    do_ecc     = hit & ecc_elig;
    do_par     = hit & cmd_q.par_en;
    if (cmd_wr)   fired_d = 1'b0;
    else if (hit) fired_d = 1'b1;
    else          fired_d = fired_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fired_d;
  end

  // R9: a command write clears the fired flag
  p_cmd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !fired_q);
  // R3: a spent one-shot blocks further injection
  p_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !cmd_q.repeat_en) |-> !(do_ecc || do_par));
  // R1: reads never inject
  p_read_no_inj_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> !(do_ecc || do_par));
  // R8: upper-half beats never take a check-bit flip under half-line mode
  p_half_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.half_line && !lower_half) |-> !do_ecc);
endmodule

// File: rtl/wpath_err_inject.sv
module wpath_err_inject
  import wpi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BEAT_W-1:0] req_beat,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ECC_W-1:0]  req_ecc,
  output logic              out_valid,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [ECC_W-1:0]  out_ecc,
  output logic              out_apar,
  output logic              inj_status
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [ADDR_W-1:0] pattern_q, dontcare_q;
  logic [ECC_W-1:0]  flipmask_q;
  inj_cmd_t          cmd_q;
  logic              cmd_wr, match, do_ecc, do_par, fired_q;

  wpi_cfg_regs #(.ADDR_W(ADDR_W), .ECC_W(ECC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pattern_q(pattern_q), .dontcare_q(dontcare_q),
    .flipmask_q(flipmask_q), .cmd_q(cmd_q), .cmd_wr(cmd_wr)
  );

  wpi_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(req_addr), .pattern(pattern_q), .dontcare(dontcare_q), .match(match)
  );

  wpi_arm_ctrl #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_arm (
    .clk(clk), .rst_n(rst_n_s), .cmd_q(cmd_q), .cmd_wr(cmd_wr),
    .req_valid(req_valid), .req_write(req_write), .req_beat(req_beat),
    .match(match), .do_ecc(do_ecc), .do_par(do_par), .fired_q(fired_q)
  );

  // output stage: next-state
  logic              load_en;
  logic [ECC_W-1:0]  ecc_d;
  logic              apar_d;
  logic              valid_q, write_q, apar_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ECC_W-1:0]  ecc_q;

  always_comb begin
    load_en = req_valid;
    ecc_d   = req_ecc ^ (do_ecc ? flipmask_q : '0);
    apar_d  = (^req_addr) ^ do_par;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) valid_q <= 1'b0;
    else          valid_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      ecc_q   <= '0;
      apar_q  <= 1'b0;
    end else if (load_en) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      data_q  <= req_data;
      ecc_q   <= ecc_d;
      apar_q  <= apar_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_write  = write_q;
  assign out_addr   = addr_q;
  assign out_data   = data_q;
  assign out_ecc    = ecc_q;
  assign out_apar   = apar_q;
  assign inj_status = fired_q;

  // R1: reads leave with untouched check bits and true parity
  p_read_pass_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(req_valid) && !$past(req_write)) |->
      (out_ecc == $past(req_ecc) && out_apar == ^out_addr));
  // R10: address and data pass through with one cycle of latency
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> (out_valid && out_addr == $past(req_addr) && out_data == $past(req_data)));
  // R6: with both enables set, the two corruptions coincide
  p_shared_match_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_q.ecc_en && cmd_q.par_en && !cmd_q.half_line && flipmask_q != '0 && req_valid) |=>
      ((out_ecc != $past(req_ecc)) == (out_apar != ^out_addr)));
endmodule

// File: tb/test_wpath_err_inject.sv
module test_wpath_err_inject;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int ECC_W  = 8;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BEAT_W-1:0] req_beat = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [ECC_W-1:0]  req_ecc = '0;
  logic              out_valid, out_write, out_apar, inj_status;
  logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data;
  logic [ECC_W-1:0]  out_ecc;

  always #10 clk = ~clk; // 50 MHz

  wpath_err_inject #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W), .BEATS(BEATS)) i_wpath_err_inject (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_beat(req_beat),
    .req_data(req_data), .req_ecc(req_ecc), .out_valid(out_valid), .out_write(out_write),
    .out_addr(out_addr), .out_data(out_data), .out_ecc(out_ecc), .out_apar(out_apar),
    .inj_status(inj_status)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one request, checks it one edge later
  task automatic request(input string req, input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [BEAT_W-1:0] b, input logic [ECC_W-1:0] e,
                         input logic [ECC_W-1:0] exp_e, input logic exp_pf, input logic exp_st);
    logic [DATA_W-1:0] d;
    d = {a, ~a};
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_beat = b; req_data = d; req_ecc = e;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "valid", 64'(out_valid), 64'd1);
    check("R10", "write", 64'(out_write), 64'(wr));
    check("R10", "addr", 64'(out_addr), 64'(a));
    check("R10", "data", out_data, d);
    check(req, "ecc", 64'(out_ecc), 64'(exp_e));
    check(req, "apar", 64'(out_apar), 64'((^a) ^ exp_pf));
    check(req, "status", 64'(inj_status), 64'(exp_st));
  endtask

  typedef struct packed {
    logic              cmd_wr;
    logic [3:0]        cmd;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BEAT_W-1:0] beat;
    logic [ECC_W-1:0]  ecc;
    logic [ECC_W-1:0]  exp_ecc;
    logic              exp_pf;
    logic              exp_st;
    logic [3:0]        req;
  } vec_t;

  // command bits: [0] ecc, [1] parity, [2] repeat, [3] half line
  // pattern 0x1240, don't-care 0xF, flip mask 0x81
  localparam vec_t VECS [15] = '{
    '{1'b1, 4'b0001, 1'b1, 32'h1244, 2'd0, 8'h3C, 8'hBD, 1'b0, 1'b1, 4'd3}, // R3 first hit
    '{1'b0, 4'b0000, 1'b1, 32'h1244, 2'd0, 8'h3C, 8'h3C, 1'b0, 1'b1, 4'd3}, // R3 spent
    '{1'b1, 4'b0101, 1'b1, 32'h124F, 2'd3, 8'h00, 8'h81, 1'b0, 1'b1, 4'd4}, // R4 repeat
    '{1'b0, 4'b0000, 1'b1, 32'h1241, 2'd0, 8'hFF, 8'h7E, 1'b0, 1'b1, 4'd4}, // R4 again
    '{1'b0, 4'b0000, 1'b0, 32'h1241, 2'd0, 8'hFF, 8'hFF, 1'b0, 1'b1, 4'd1}, // R1 read
    '{1'b0, 4'b0000, 1'b1, 32'h1250, 2'd0, 8'h11, 8'h11, 1'b0, 1'b1, 4'd2}, // R2 no match
    '{1'b1, 4'b0010, 1'b1, 32'h1243, 2'd1, 8'h11, 8'h11, 1'b1, 1'b1, 4'd6}, // R6 parity only
    '{1'b0, 4'b0000, 1'b1, 32'h1243, 2'd1, 8'h11, 8'h11, 1'b0, 1'b1, 4'd3}, // R3 parity spent
    '{1'b1, 4'b0011, 1'b1, 32'h1240, 2'd0, 8'h00, 8'h81, 1'b1, 1'b1, 4'd6}, // R6 both
    '{1'b1, 4'b1001, 1'b1, 32'h1240, 2'd2, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8}, // R8 upper half
    '{1'b0, 4'b0000, 1'b1, 32'h1240, 2'd1, 8'h00, 8'h81, 1'b0, 1'b1, 4'd8}, // R8 lower half
    '{1'b1, 4'b0000, 1'b1, 32'h1240, 2'd0, 8'h22, 8'h22, 1'b0, 1'b0, 4'd5}, // R5 zero command
    '{1'b1, 4'b1011, 1'b1, 32'h1242, 2'd3, 8'h5A, 8'h5A, 1'b1, 1'b1, 4'd7}, // R7 parity, upper beat
    '{1'b1, 4'b0001, 1'b0, 32'h1240, 2'd0, 8'h5A, 8'h5A, 1'b0, 1'b0, 4'd1}, // R1 read not consumed
    '{1'b0, 4'b0000, 1'b1, 32'h1240, 2'd0, 8'h5A, 8'hDB, 1'b0, 1'b1, 4'd7}  // R7 xor mask
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", "out_valid in reset", 64'(out_valid), 64'd0);
    check("R11", "status in reset", 64'(inj_status), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", "out_valid after reset", 64'(out_valid), 64'd0);
    // R11: config cleared, so a write passes untouched
    request("R11", 1'b1, 32'h0, 2'd0, 8'h66, 8'h66, 1'b0, 1'b0);

    // R2: pattern, don't-care, flip mask
    cfg_write(2'd0, 32'h0000_1240);
    cfg_write(2'd1, 32'h0000_000F);
    cfg_write(2'd2, 32'h0000_0081);

    for (int i = 0; i < 15; i++) begin
      if (VECS[i].cmd_wr) cfg_write(2'd3, 32'(VECS[i].cmd));
      request($sformatf("R%0d", VECS[i].req), VECS[i].wr, VECS[i].addr, VECS[i].beat,
              VECS[i].ecc, VECS[i].exp_ecc, VECS[i].exp_pf, VECS[i].exp_st);
    end

    // R9: command write clears status at once
    cfg_write(2'd3, 32'h5);
    check("R9", "status after command write", 64'(inj_status), 64'd0);

    // R9: request in same cycle as a zero command uses the old repeat setting
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h1240; req_beat = '0;
    req_data = 64'h1; req_ecc = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R9", "same-cycle ecc", 64'(out_ecc), 64'h81);
    check("R9", "status cleared by command", 64'(inj_status), 64'd0);
    request("R5", 1'b1, 32'h1240, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);

    // R2: pattern change; masked bits only
    cfg_write(2'd3, 32'h5);
    request("R2", 1'b1, 32'h0000_3240, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    request("R2", 1'b1, 32'h0000_124A, 2'd0, 8'h00, 8'h81, 1'b0, 1'b1);

    // R11: mid-run reset clears status and configuration
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11", "status on reset", 64'(inj_status), 64'd0);
    check("R11", "valid on reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    request("R11", 1'b1, 32'h1240, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule